// File: doc/BRIEF.md
# Flash Program and Erase Sequencer with Erase Suspend

This block runs the embedded operations of a behavioural two-plane flash array. A command decoder upstream hands it one-cycle command pulses: word program, sector erase, chip erase, erase suspend, erase resume and sector lock. The sequencer times each operation with cycle counters that stand in for the real program and erase durations. It owns the word storage and one lock bit per sector, and it exposes a one-cycle read port for the array contents.

An erase has two phases. A timed wait comes first. A sweep then writes all ones, one word per cycle, so that the storage maps onto a dual-port block RAM. A running erase can be suspended. While it is suspended, the array can be read and words outside the erasing sector can be programmed. A later resume carrying the right plane address continues the erase from the point where it stopped.

Sectors are uniform, with 2**SECT_W words each. The sector index is `cmd_addr[ADDR_W-1:SECT_W]`. Sectors with an index below PLANE_SPLIT belong to plane A and the rest to plane B. The command codes are: 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 lock.

Top module: `flash_seq_top`

## Requirements
- R1: A program command (code 0) accepted for an unlocked word stores the old word ANDed with `cmd_data`, so bits can only go from 1 to 0. Any erased word reads as all ones.
- R2: After a program is accepted, `ready` is low for exactly PROG_CYC cycles and `act_addr` shows the target word. The new value is readable once `ready` is high again.
- R3: A lock command (code 5) sets the lock bit of the sector that holds `cmd_addr`. A sector erase (code 1) of a locked sector holds `ready` low for exactly ABORT_CYC cycles and changes no data. A program aimed at a locked sector is refused.
- R4: A chip erase (code 2) sets every word of the unlocked sectors to all ones and leaves the words of locked sectors unchanged.
- R5: While `lock_override` is high, locked sectors can be programmed and erased like unlocked ones.
- R6: A suspend (code 3) is accepted only while an erase is in its wait or sweep phase. Exactly SUSP_CYC cycles after acceptance, `erase_suspended` is high, `ready` is high and `plane_busy` is zero. No erase write happens while suspended, and words in other sectors can be read and programmed.
- R7: While an erase is suspended, a program to a word inside the erasing sector is refused. During a suspended chip erase, every program is refused.
- R8: While an erase is suspended, new sector or chip erase commands are refused.
- R9: A resume (code 4) is accepted only if the sector of `cmd_addr` lies in the same plane as the suspended sector; for a suspended chip erase, any plane is accepted. After an accepted resume the erase continues to completion.
- R10: While any operation is active, every command except suspend is ignored.
- R11: Reset aborts any operation and clears all lock bits. In the cycle after reset, `ready` is high, `plane_busy` is zero and `erase_suspended` is low. The word that was being programmed is left undefined.
- R12: `plane_busy[0]` is high while an operation is active in plane A and `plane_busy[1]` while one is active in plane B. A chip erase raises both bits. `ready` is low exactly when `plane_busy` is non-zero.
- R13: `rd_data` shows the word at `rd_addr` one clock cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command pulse |
| cmd_op | input | 3 | Command code (0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 lock) |
| cmd_addr | input | ADDR_W | Word address, sector address or plane address |
| cmd_data | input | DATA_W | Program data |
| lock_override | input | 1 | Allows program and erase of locked sectors while high |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, one cycle after rd_addr |
| ready | output | 1 | High when no operation is running (a suspended erase counts as not running) |
| plane_busy | output | 2 | Per-plane activity, bit 0 plane A, bit 1 plane B |
| erase_suspended | output | 1 | High while an erase is held in suspension |
| act_addr | output | ADDR_W | Program target, or erase sweep position |

## Verification
The assertions assume that commands arrive as single-cycle pulses and that `lock_override` stays steady while an erase of a locked sector is in progress. They also assume that nothing else writes the array. The stimulus meets these assumptions. Every command is driven for exactly one cycle between falling edges. The override is raised before the erase command and lowered only after `ready` returns high. Reset is applied at the start, and once more only in the final program-abort case.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  typedef enum logic [2:0] {
    OP_PROG       = 3'd0,
    OP_SECT_ERASE = 3'd1,
    OP_CHIP_ERASE = 3'd2,
    OP_SUSPEND    = 3'd3,
    OP_RESUME     = 3'd4,
    OP_LOCK       = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ES_IDLE,
    ES_WAIT,
    ES_SWEEP,
    ES_ABORT,
    ES_HOLD,
    ES_SUSP
  } erase_st_e;
endpackage

// File: rtl/flash_store.sv
`timescale 1ns/1ps
module flash_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_q,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-only port for the external reader
  always_ff @(posedge clk) begin
    a_q <= mem[a_addr];
  end

  // read-first port used by the program and erase engines
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/flash_prog_unit.sv
`timescale 1ns/1ps
module flash_prog_unit #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] old_q,
  output logic              busy,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              we,
  output logic [DATA_W-1:0] wdata
);
  localparam int CNT_W = $clog2(PROG_CYC + 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] dat_q;
  logic [CNT_W-1:0]  run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      tgt_addr <= '0;
      dat_q    <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(PROG_CYC - 1);
      tgt_addr <= addr;
      dat_q    <= data;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // the old word arrives one cycle after the target address is held
  assign we    = busy && (cnt == '0);
  assign wdata = old_q & dat_q;

  // independent length counter for the program window
  always_ff @(posedge clk) begin
    if (rst || start) run_len <= '0;
    else if (busy)    run_len <= run_len + 1'b1;
  end

  // R2: the commit lands on the last of PROG_CYC busy cycles
  a_r2_prog_length: assert property (@(posedge clk) disable iff (rst)
    we |-> (run_len == CNT_W'(PROG_CYC - 1)));

  // R10: no new start while a program is in flight
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/flash_erase_unit.sv
`timescale 1ns/1ps
module flash_erase_unit
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SECT_W     = 4,
  parameter int SERASE_CYC = 20,
  parameter int CERASE_CYC = 30,
  parameter int ABORT_CYC  = 3,
  parameter int SUSP_CYC   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_sect,
  input  logic                           start_chip,
  input  logic [ADDR_W-SECT_W-1:0]       sect_in,
  input  logic                           sect_locked,
  input  logic                           suspend_req,
  input  logic                           resume_req,
  input  logic [(1<<(ADDR_W-SECT_W))-1:0] lock_vec,
  input  logic                           override,
  output erase_st_e                      st,
  output logic                           we,
  output logic [ADDR_W-1:0]              waddr,
  output logic                           chip,
  output logic [ADDR_W-SECT_W-1:0]       sect
);
  localparam int SIDX_W = ADDR_W - SECT_W;
  localparam int M1     = (SERASE_CYC > CERASE_CYC) ? SERASE_CYC : CERASE_CYC;
  localparam int M2     = (M1 > ABORT_CYC) ? M1 : ABORT_CYC;
  localparam int CNT_W  = $clog2(M2 + 1);
  localparam int SC_W   = $clog2(SUSP_CYC + 1);

  erase_st_e          ret_st;
  logic [CNT_W-1:0]   cnt;
  logic [SC_W-1:0]    scnt;
  logic [ADDR_W-1:0]  ptr;
  logic [SIDX_W-1:0]  ptr_sect;
  logic               unlocked;
  logic               sweep_last;

  assign ptr_sect   = ptr[ADDR_W-1:SECT_W];
  assign unlocked   = !lock_vec[ptr_sect] || override;
  assign sweep_last = chip ? (&ptr) : (&ptr[SECT_W-1:0]);
  assign we         = (st == ES_SWEEP) && !suspend_req && unlocked;
  assign waddr      = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ES_IDLE;
      ret_st <= ES_IDLE;
      cnt    <= '0;
      scnt   <= '0;
      ptr    <= '0;
      chip   <= 1'b0;
      sect   <= '0;
    end else begin
      case (st)
        ES_IDLE: begin
          if (start_chip) begin
            st   <= ES_WAIT;
            chip <= 1'b1;
            sect <= '0;
            ptr  <= '0;
            cnt  <= CNT_W'(CERASE_CYC - 1);
          end else if (start_sect) begin
            chip <= 1'b0;
            sect <= sect_in;
            ptr  <= {sect_in, {SECT_W{1'b0}}};
            if (sect_locked) begin
              st  <= ES_ABORT;
              cnt <= CNT_W'(ABORT_CYC - 1);
            end else begin
              st  <= ES_WAIT;
              cnt <= CNT_W'(SERASE_CYC - 1);
            end
          end
        end
        ES_WAIT: begin
          if (suspend_req) begin
            st     <= ES_HOLD;
            ret_st <= ES_WAIT;
            scnt   <= SC_W'(SUSP_CYC - 1);
          end else if (cnt == '0) begin
            st <= ES_SWEEP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ES_SWEEP: begin
          if (suspend_req) begin
            st     <= ES_HOLD;
            ret_st <= ES_SWEEP;
            scnt   <= SC_W'(SUSP_CYC - 1);
          end else if (sweep_last) begin
            st <= ES_IDLE;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        ES_HOLD: begin
          if (scnt == '0) st   <= ES_SUSP;
          else            scnt <= scnt - 1'b1;
        end
        ES_SUSP: begin
          if (resume_req) st <= ret_st;
        end
        ES_ABORT: begin
          if (cnt == '0) st  <= ES_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ES_IDLE;
      endcase
    end
  end

  // separate counter bounding the suspend latency
  logic [SC_W:0] hold_len;
  always_ff @(posedge clk) begin
    if (rst || st != ES_HOLD) hold_len <= '0;
    else                      hold_len <= hold_len + 1'b1;
  end

  // R6: the erase settles into suspension within SUSP_CYC cycles
  a_r6_suspend_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ES_HOLD) |-> (hold_len < (SC_W + 1)'(SUSP_CYC)));

  // R9: a resume only ever applies to a suspended erase
  a_r9_resume_from_susp: assert property (@(posedge clk) disable iff (rst)
    resume_req |-> (st == ES_SUSP));

  // R6: no sweep write in suspension
  a_r6_quiet_when_held: assert property (@(posedge clk) disable iff (rst)
    (st == ES_SUSP || st == ES_HOLD) |-> !we);
endmodule

// File: rtl/flash_seq_top.sv
`timescale 1ns/1ps
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SECT_W      = 4,
  parameter int PLANE_SPLIT = (1 << (ADDR_W - SECT_W)) / 2,
  parameter int PROG_CYC    = 4,
  parameter int SERASE_CYC  = 20,
  parameter int CERASE_CYC  = 30,
  parameter int ABORT_CYC   = 3,
  parameter int SUSP_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              lock_override,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready,
  output logic [1:0]        plane_busy,
  output logic              erase_suspended,
  output logic [ADDR_W-1:0] act_addr
);
  localparam int SIDX_W   = ADDR_W - SECT_W;
  localparam int NUM_SECT = 1 << SIDX_W;

  function automatic logic plane_of(input logic [SIDX_W-1:0] s);
    return s >= SIDX_W'(PLANE_SPLIT);
  endfunction

  // ---------------- command decode ----------------
  logic [SIDX_W-1:0]   c_sect;
  logic                c_locked;
  logic [NUM_SECT-1:0] lock_q;
  logic [NUM_SECT-1:0] lock_hit;

  logic                p_busy, p_we;
  logic [ADDR_W-1:0]   p_addr;
  logic [DATA_W-1:0]   p_wdata, b_q;

  erase_st_e           e_st;
  logic                e_we, e_chip;
  logic [ADDR_W-1:0]   e_waddr;
  logic [SIDX_W-1:0]   e_sect;

  logic e_idle, e_susp, e_run, e_active;
  logic acc_prog, acc_serase, acc_cerase, acc_susp, acc_resume, acc_lock;

  assign c_sect   = cmd_addr[ADDR_W-1:SECT_W];
  assign c_locked = lock_q[c_sect] && !lock_override;

  assign e_idle   = (e_st == ES_IDLE);
  assign e_susp   = (e_st == ES_SUSP);
  assign e_run    = (e_st == ES_WAIT) || (e_st == ES_SWEEP);
  assign e_active = e_run || (e_st == ES_ABORT) || (e_st == ES_HOLD);

  assign acc_prog   = cmd_valid && (cmd_op == OP_PROG) && !p_busy && !c_locked &&
                      (e_idle || (e_susp && !e_chip && (c_sect != e_sect)));
  assign acc_serase = cmd_valid && (cmd_op == OP_SECT_ERASE) && !p_busy && e_idle;
  assign acc_cerase = cmd_valid && (cmd_op == OP_CHIP_ERASE) && !p_busy && e_idle;
  assign acc_susp   = cmd_valid && (cmd_op == OP_SUSPEND) && !p_busy && e_run;
  assign acc_resume = cmd_valid && (cmd_op == OP_RESUME) && !p_busy && e_susp &&
                      (e_chip || (plane_of(c_sect) == plane_of(e_sect)));
  assign acc_lock   = cmd_valid && (cmd_op == OP_LOCK) && !p_busy && e_idle;

  // ---------------- lock bits ----------------
  for (genvar g = 0; g < NUM_SECT; g++) begin : g_lock
    assign lock_hit[g] = acc_lock && (c_sect == SIDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= '0;
    else     lock_q <= lock_q | lock_hit;
  end

  // ---------------- engines ----------------
  flash_prog_unit #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PROG_CYC(PROG_CYC)
  ) prog_i (
    .clk     (clk),
    .rst     (rst),
    .start   (acc_prog),
    .addr    (cmd_addr),
    .data    (cmd_data),
    .old_q   (b_q),
    .busy    (p_busy),
    .tgt_addr(p_addr),
    .we      (p_we),
    .wdata   (p_wdata)
  );

  flash_erase_unit #(
    .ADDR_W    (ADDR_W),
    .SECT_W    (SECT_W),
    .SERASE_CYC(SERASE_CYC),
    .CERASE_CYC(CERASE_CYC),
    .ABORT_CYC (ABORT_CYC),
    .SUSP_CYC  (SUSP_CYC)
  ) erase_i (
    .clk        (clk),
    .rst        (rst),
    .start_sect (acc_serase),
    .start_chip (acc_cerase),
    .sect_in    (c_sect),
    .sect_locked(c_locked),
    .suspend_req(acc_susp),
    .resume_req (acc_resume),
    .lock_vec   (lock_q),
    .override   (lock_override),
    .st         (e_st),
    .we         (e_we),
    .waddr      (e_waddr),
    .chip       (e_chip),
    .sect       (e_sect)
  );

  // ---------------- storage ----------------
  logic [ADDR_W-1:0] b_addr;
  logic              b_we;
  logic [DATA_W-1:0] b_wdata;

  assign b_addr  = p_busy ? p_addr : e_waddr;
  assign b_we    = p_we | e_we;
  assign b_wdata = p_busy ? p_wdata : {DATA_W{1'b1}};

  flash_store #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) store_i (
    .clk    (clk),
    .a_addr (rd_addr),
    .a_q    (rd_data),
    .b_addr (b_addr),
    .b_we   (b_we),
    .b_wdata(b_wdata),
    .b_q    (b_q)
  );

  // ---------------- status ----------------
  logic p_plane, e_plane;
  assign p_plane = plane_of(p_addr[ADDR_W-1:SECT_W]);
  assign e_plane = plane_of(e_sect);

  assign plane_busy[0]   = (p_busy && !p_plane) || (e_active && (e_chip || !e_plane));
  assign plane_busy[1]   = (p_busy &&  p_plane) || (e_active && (e_chip ||  e_plane));
  assign ready           = !p_busy && (e_idle || e_susp);
  assign erase_suspended = e_susp;
  assign act_addr        = p_busy ? p_addr : e_waddr;

  // ---------------- assertions ----------------
  // R3: an erase write never lands in a locked sector without override
  a_r3_locked_untouched: assert property (@(posedge clk) disable iff (rst)
    e_we |-> (!lock_q[e_waddr[ADDR_W-1:SECT_W]] || lock_override));

  // R3: the abort window writes nothing
  a_r3_abort_silent: assert property (@(posedge clk) disable iff (rst)
    (e_st == ES_ABORT) |-> !b_we);

  // R7: a program during suspension stays outside the erasing scope
  a_r7_prog_outside: assert property (@(posedge clk) disable iff (rst)
    (p_we && e_susp) |-> (!e_chip && (p_addr[ADDR_W-1:SECT_W] != e_sect)));

  // R8: no erase is launched while one is suspended
  a_r8_no_nested_erase: assert property (@(posedge clk) disable iff (rst)
    e_susp |-> !(acc_serase || acc_cerase));

  // R6: the two engines never write in the same cycle
  a_r6_single_writer: assert property (@(posedge clk) disable iff (rst)
    !(p_we && e_we));

  // R12: ready agrees with the per-plane activity flags
  a_r12_ready_vs_planes: assert property (@(posedge clk) disable iff (rst)
    ready == (plane_busy == 2'b00));
endmodule

// File: tb/flash_seq_top_tb_top.sv
`timescale 1ns/1ps
module flash_seq_top_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int SW = 4;
  localparam int PROG = 4;
  localparam int SE = 20;
  localparam int CE = 30;
  localparam int AB = 3;
  localparam int SU = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          lock_override = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          ready;
  logic [1:0]    plane_busy;
  logic          erase_suspended;
  logic [AW-1:0] act_addr;

  flash_seq_top #(
    .ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .PLANE_SPLIT(2),
    .PROG_CYC(PROG), .SERASE_CYC(SE), .CERASE_CYC(CE),
    .ABORT_CYC(AB), .SUSP_CYC(SU)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .lock_override(lock_override),
    .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready),
    .plane_busy(plane_busy), .erase_suspended(erase_suspended),
    .act_addr(act_addr)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int            stamp;
    logic [DW-1:0] exp;
    string         tag;
  } rd_item_t;

  rd_item_t sb_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each read one cycle after its address
  always @(negedge clk) begin : mon
    rd_item_t it;
    if (sb_q.size() > 0 && sb_q[0].stamp == cyc - 1) begin
      it = sb_q.pop_front();
      chk(rd_data === it.exp, it.tag, int'(rd_data), int'(it.exp));
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    @(negedge clk);
    rd_addr = a;
    sb_q.push_back('{cyc, e, tag});
  endtask

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = a;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic settle;
    int n;
    busy_len(n);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(ready == 1'b1, "R11 ready after reset", ready, 1);
    chk(plane_busy == 2'b00, "R11 plane_busy after reset", plane_busy, 0);
    chk(erase_suspended == 1'b0, "R11 suspended after reset", erase_suspended, 0);

    // chip erase to a known state, R12 both planes busy
    issue(3'd2, '0, '0);
    chk(plane_busy == 2'b11, "R12 chip erase both planes", plane_busy, 3);
    settle();
    rd(6'h00, 16'hFFFF, "R4 R13 erased word");
    rd(6'h3F, 16'hFFFF, "R4 R13 erased last word");

    // R2 program length and address, R12 plane A
    issue(3'd0, 6'h05, 16'h1234);
    chk(ready == 1'b0, "R2 ready low in program", ready, 0);
    chk(act_addr == 6'h05, "R2 act_addr", act_addr, 5);
    chk(plane_busy == 2'b01, "R12 program plane A", plane_busy, 1);
    busy_len(n);
    chk(n == PROG, "R2 program cycles", n, PROG);
    rd(6'h05, 16'h1234, "R1 first program");

    // R1 AND semantics
    issue(3'd0, 6'h05, 16'hFF0F);
    settle();
    rd(6'h05, 16'h1204, "R1 program only clears bits");

    // R10 second program while busy is ignored
    issue(3'd0, 6'h06, 16'h0000);
    issue(3'd0, 6'h07, 16'h0000);
    settle();
    rd(6'h06, 16'h0000, "R10 first program done");
    rd(6'h07, 16'hFFFF, "R10 command during busy ignored");

    // R3 lock and aborted erase
    issue(3'd0, 6'h11, 16'h00FF);
    settle();
    issue(3'd5, 6'h10, '0);
    issue(3'd1, 6'h10, '0);
    busy_len(n);
    chk(n == AB, "R3 locked erase abort cycles", n, AB);
    rd(6'h11, 16'h00FF, "R3 locked sector unchanged");
    issue(3'd0, 6'h12, 16'h0000);
    chk(ready == 1'b1, "R3 program to locked refused", ready, 1);
    rd(6'h12, 16'hFFFF, "R3 locked word not programmed");

    // R4 chip erase keeps locked sector
    issue(3'd0, 6'h20, 16'h0000);
    settle();
    issue(3'd2, '0, '0);
    settle();
    rd(6'h05, 16'hFFFF, "R4 unlocked plane A erased");
    rd(6'h20, 16'hFFFF, "R4 unlocked plane B erased");
    rd(6'h11, 16'h00FF, "R4 locked sector kept");

    // R5 override
    lock_override = 1'b1;
    issue(3'd0, 6'h12, 16'h0F0F);
    settle();
    rd(6'h12, 16'h0F0F, "R5 program locked with override");
    issue(3'd1, 6'h10, '0);
    settle();
    lock_override = 1'b0;
    rd(6'h11, 16'hFFFF, "R5 erase locked with override");
    rd(6'h12, 16'hFFFF, "R5 erase locked with override second word");

    // R6 to R9 suspend / resume
    issue(3'd0, 6'h21, 16'h2222);
    settle();
    issue(3'd0, 6'h30, 16'h1111);
    settle();
    issue(3'd1, 6'h20, '0);
    chk(plane_busy == 2'b10, "R12 sector erase plane B", plane_busy, 2);
    repeat (3) @(negedge clk);
    issue(3'd3, '0, '0);
    repeat (SU) @(negedge clk);
    chk(erase_suspended == 1'b1, "R6 suspended after latency", erase_suspended, 1);
    chk(ready == 1'b1, "R6 ready while suspended", ready, 1);
    chk(plane_busy == 2'b00, "R6 no plane busy while suspended", plane_busy, 0);
    rd(6'h21, 16'h2222, "R6 read in suspended sector");
    issue(3'd0, 6'h30, 16'h0101);
    settle();
    rd(6'h30, 16'h0101, "R6 program other sector in suspend");
    issue(3'd0, 6'h22, 16'h0000);
    chk(ready == 1'b1, "R7 program to erasing sector refused", ready, 1);
    rd(6'h22, 16'hFFFF, "R7 erasing sector word untouched");
    issue(3'd1, 6'h30, '0);
    chk(ready == 1'b1, "R8 erase refused in suspend", ready, 1);
    rd(6'h30, 16'h0101, "R8 other sector not erased");
    issue(3'd4, 6'h05, '0);
    chk(erase_suspended == 1'b1, "R9 resume wrong plane ignored", erase_suspended, 1);
    issue(3'd4, 6'h2F, '0);
    chk(erase_suspended == 1'b0, "R9 resume right plane", erase_suspended, 0);
    chk(ready == 1'b0, "R9 erase running again", ready, 0);
    settle();
    rd(6'h21, 16'hFFFF, "R9 erase completed");
    rd(6'h30, 16'h0101, "R9 other sector kept");

    // R11 reset during program
    issue(3'd0, 6'h31, 16'h0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(ready == 1'b1, "R11 ready after mid-program reset", ready, 1);
    chk(plane_busy == 2'b00, "R11 planes idle after reset", plane_busy, 0);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R13 all reads compared", sb_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule